// File: doc/BRIEF.md
# Serial Command Receiver and Decoder

This block sits between a host microcontroller and the servo and audio logic of a disc playback chip. The host sends command bytes over three wires: a write-enable strobe, a data line and a shift clock. While the strobe is high, each rising edge of the shift clock moves one data bit into a byte assembler, most significant bit first. The first complete byte is the opcode. A second complete byte, if one arrives, is the operand.

When the strobe falls, the opcode is decoded and acted on. Some opcodes set modes that persist: the output channel routing, the direction of four general-purpose ports, and the internal brake mode. Others produce a one-cycle pulse for a neighbouring block. All three serial inputs are asynchronous to the system clock. They pass through synchronizers and edge detectors before any logic uses them.

Top module: `cmd_rx_top`

## Requirements
- R1: After reset, `route_mono_o` is 0 (stereo: left to left, right to right), `port_dir_o` is all zeros (all ports are inputs), `brake_mode_o` is 0, and neither `brake_pulse_o` nor `cmd_done_o` is asserted.
- R2: Data bits are taken MSB first, only on rising edges of `sclk_i` while `wen_i` is high. Shift-clock edges while `wen_i` is low have no effect. Bits after the first 16 in a strobe window are ignored.
- R3: A command takes effect at the falling edge of `wen_i`. With the default two-stage synchronizer, its outputs change on the third rising edge of `clk_i` after `wen_i` falls.
- R4: Opcode 0x28 sets `route_mono_o` to 0 (stereo routing).
- R5: Opcode 0x29 sets `route_mono_o` to 1 (left-channel data on both outputs).
- R6: Opcode 0xDB followed by an operand byte in the same strobe window loads operand bits 5..2 into `port_dir_o[3:0]`. Operand bit 2 maps to `port_dir_o[0]`. A 1 in a bit makes that port an output and a 0 makes it an input.
- R7: An opcode 0xDB whose operand byte is not complete when the strobe falls leaves `port_dir_o` unchanged and raises no `cmd_done_o`.
- R8: Opcode 0xC5 sets `brake_mode_o` to 1. It stays at 1 until reset.
- R9: Opcode 0x06 raises `brake_pulse_o` for exactly one clock cycle and changes no mode output.
- R10: A strobe window with fewer than 8 bits changes no output and raises no pulse. So does any opcode other than 0x28, 0x29, 0xDB, 0xC5 and 0x06.
- R11: Each executed command raises `cmd_done_o` for one cycle, in the same cycle as its effect, with `cmd_op_o` holding the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wen_i | input | 1 | Write-enable strobe from the host (asynchronous) |
| sclk_i | input | 1 | Serial shift clock from the host (asynchronous) |
| sdat_i | input | 1 | Serial command data (asynchronous) |
| route_mono_o | output | 1 | 1: left channel routed to both outputs; 0: stereo |
| port_dir_o | output | NPORTS | Direction of general ports 2..5; 1 = output |
| brake_mode_o | output | 1 | Internal brake mode latched |
| brake_pulse_o | output | 1 | One-cycle brake command pulse |
| cmd_done_o | output | 1 | One-cycle pulse for each executed command |
| cmd_op_o | output | 8 | Opcode of the last executed command |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, four ports starting at operand bit 2, and 8-bit bytes. This fixes the input-to-output latency at three clock edges, so the reference model can predict every output on every cycle. These values bring into reach:
- truncated windows of 5, 8 and 12 bits;
- windows overlong by a full byte;
- idle shift clocks outside the strobe;
- the sticky brake mode;
- operands whose bits outside 5..2 are set, which would show any off-by-one in the port field.

// File: rtl/cmd_rx_pkg.sv
package cmd_rx_pkg;
  localparam int CMD_W = 8;
  localparam logic [CMD_W-1:0] OP_STEREO   = 8'h28;
  localparam logic [CMD_W-1:0] OP_LEFT_DUP = 8'h29;
  localparam logic [CMD_W-1:0] OP_PORT_DIR = 8'hDB;
  localparam logic [CMD_W-1:0] OP_BRK_MODE = 8'hC5;
  localparam logic [CMD_W-1:0] OP_BRAKE    = 8'h06;

  typedef struct packed {
    logic             valid;
    logic [CMD_W-1:0] op;
    logic [CMD_W-1:0] arg;
    logic             arg_vld;
  } cmd_t;
endpackage

// File: rtl/cmd_rx_sync.sv
module cmd_rx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] dly_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= async_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) dly_q <= '0;
    else         dly_q <= stg_q[STAGES-1];

  assign lvl_o  = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1] & ~dly_q;
  assign fall_o = ~stg_q[STAGES-1] & dly_q;
endmodule

// File: rtl/cmd_rx_framer.sv
module cmd_rx_framer
  import cmd_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wen_lvl_i,
  input  logic wen_rise_i,
  input  logic wen_fall_i,
  input  logic sclk_rise_i,
  input  logic sdat_i,
  output cmd_t cmd_o
);
  localparam int CNT_W = $clog2(CMD_W);

  logic [CMD_W-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       nbytes_q;
  logic [CMD_W-1:0] op_q, arg_q;
  logic [CMD_W-1:0] sh_nxt;

  assign sh_nxt = {sh_q[CMD_W-2:0], sdat_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      nbytes_q <= '0;
      op_q     <= '0;
      arg_q    <= '0;
    end else if (wen_rise_i) begin
      cnt_q    <= '0;
      nbytes_q <= '0;
    end else if (wen_lvl_i && sclk_rise_i && nbytes_q != 2'd2) begin
      sh_q <= sh_nxt;
      if (cnt_q == CNT_W'(CMD_W - 1)) begin
        cnt_q    <= '0;
        nbytes_q <= nbytes_q + 2'd1;
        if (nbytes_q == 2'd0) op_q  <= sh_nxt;
        else                  arg_q <= sh_nxt;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // partial first byte leaves nbytes at zero: nothing runs
  assign cmd_o.valid   = wen_fall_i && nbytes_q != 2'd0;
  assign cmd_o.op      = op_q;
  assign cmd_o.arg     = arg_q;
  assign cmd_o.arg_vld = nbytes_q == 2'd2;

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wen_lvl_i && !wen_rise_i) |=> ($stable(sh_q) && $stable(cnt_q)));

  // R2
  byte_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nbytes_q == 2'd2 && !wen_rise_i) |=> (nbytes_q == 2'd2 && $stable(arg_q)));
endmodule

// File: rtl/cmd_rx_decode.sv
module cmd_rx_decode
  import cmd_rx_pkg::*;
#(
  parameter int NPORTS   = 4,
  parameter int PORT_LSB = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_t              cmd_i,
  output logic              route_mono_o,
  output logic [NPORTS-1:0] port_dir_o,
  output logic              brake_mode_o,
  output logic              brake_pulse_o,
  output logic              cmd_done_o,
  output logic [CMD_W-1:0]  cmd_op_o
);
  logic              mono_q, bmode_q, pulse_q, done_q;
  logic [NPORTS-1:0] dir_q;
  logic [CMD_W-1:0]  op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mono_q  <= 1'b0;
      dir_q   <= '0;
      bmode_q <= 1'b0;
      pulse_q <= 1'b0;
      done_q  <= 1'b0;
      op_q    <= '0;
    end else begin
      pulse_q <= 1'b0;
      done_q  <= 1'b0;
      if (cmd_i.valid) begin
        unique case (cmd_i.op)
          OP_STEREO:   begin mono_q <= 1'b0; done_q <= 1'b1; op_q <= cmd_i.op; end
          OP_LEFT_DUP: begin mono_q <= 1'b1; done_q <= 1'b1; op_q <= cmd_i.op; end
          OP_BRK_MODE: begin bmode_q <= 1'b1; done_q <= 1'b1; op_q <= cmd_i.op; end
          OP_BRAKE:    begin pulse_q <= 1'b1; done_q <= 1'b1; op_q <= cmd_i.op; end
          OP_PORT_DIR: if (cmd_i.arg_vld) begin
            dir_q  <= cmd_i.arg[PORT_LSB +: NPORTS];
            done_q <= 1'b1;
            op_q   <= cmd_i.op;
          end
          default: ;
        endcase
      end
    end
  end

  assign route_mono_o  = mono_q;
  assign port_dir_o    = dir_q;
  assign brake_mode_o  = bmode_q;
  assign brake_pulse_o = pulse_q;
  assign cmd_done_o    = done_q;
  assign cmd_op_o      = op_q;

  // R10
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_i.valid |=> $stable({mono_q, dir_q, bmode_q}));

  // R8
  bmode_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bmode_q |=> bmode_q);

  // R9
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);

  // R11
  done_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> (done_q && op_q == OP_BRAKE));
endmodule

// File: rtl/cmd_rx_top.sv
module cmd_rx_top
  import cmd_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NPORTS      = 4,
  parameter int PORT_LSB    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wen_i,
  input  logic              sclk_i,
  input  logic              sdat_i,
  output logic              route_mono_o,
  output logic [NPORTS-1:0] port_dir_o,
  output logic              brake_mode_o,
  output logic              brake_pulse_o,
  output logic              cmd_done_o,
  output logic [CMD_W-1:0]  cmd_op_o
);
  localparam int IDX_WEN = 0;
  localparam int IDX_CLK = 1;
  localparam int IDX_DAT = 2;

  logic [2:0] lvl, rise, fall;
  cmd_t       cmd;

  cmd_rx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({sdat_i, sclk_i, wen_i}),
    .lvl_o   (lvl),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  cmd_rx_framer u_framer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wen_lvl_i   (lvl[IDX_WEN]),
    .wen_rise_i  (rise[IDX_WEN]),
    .wen_fall_i  (fall[IDX_WEN]),
    .sclk_rise_i (rise[IDX_CLK]),
    .sdat_i      (lvl[IDX_DAT]),
    .cmd_o       (cmd)
  );

  cmd_rx_decode #(.NPORTS(NPORTS), .PORT_LSB(PORT_LSB)) u_decode (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_i         (cmd),
    .route_mono_o  (route_mono_o),
    .port_dir_o    (port_dir_o),
    .brake_mode_o  (brake_mode_o),
    .brake_pulse_o (brake_pulse_o),
    .cmd_done_o    (cmd_done_o),
    .cmd_op_o      (cmd_op_o)
  );

  // R3
  exec_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd.valid |-> (!lvl[IDX_WEN] && $past(lvl[IDX_WEN])));
endmodule

// File: tb/cmd_rx_top_tb_top.sv
module cmd_rx_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wen = 1'b0, sclk = 1'b0, sdat = 1'b0;
  logic       mono, bmode, bpulse, done;
  logic [3:0] dir;
  logic [7:0] op;

  int vectors = 0;
  int errors  = 0;
  bit running = 1'b1;

  logic       exp_mono = 1'b0, exp_bmode = 1'b0, exp_pulse = 1'b0, exp_done = 1'b0;
  logic [3:0] exp_dir = '0;
  logic [7:0] exp_op = '0;
  string      phase = "R1 reset";

  always #2 clk = ~clk;

  cmd_rx_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wen_i(wen), .sclk_i(sclk), .sdat_i(sdat),
    .route_mono_o(mono), .port_dir_o(dir), .brake_mode_o(bmode),
    .brake_pulse_o(bpulse), .cmd_done_o(done), .cmd_op_o(op)
  );

  task automatic cmp(string tag, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s) at %0t: actual %h expected %h", tag, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (running && $time > 4) begin
    cmp("R4/R5 route", {7'd0, mono}, {7'd0, exp_mono});
    cmp("R6/R7 port_dir", {4'd0, dir}, {4'd0, exp_dir});
    cmp("R8 brake_mode", {7'd0, bmode}, {7'd0, exp_bmode});
    cmp("R9 brake_pulse", {7'd0, bpulse}, {7'd0, exp_pulse});
    cmp("R11 cmd_done", {7'd0, done}, {7'd0, exp_done});
    cmp("R11 cmd_op", op, exp_op);
  end

  // reference: bits in the window, first byte opcode, second operand
  task automatic apply_model(int n, logic [23:0] pat);
    logic [7:0] o, a;
    o = pat[23:16];
    a = pat[15:8];
    if (n < 8) return;  // R10
    case (o)
      8'h28: begin exp_mono = 1'b0; exp_done = 1'b1; exp_op = o; end
      8'h29: begin exp_mono = 1'b1; exp_done = 1'b1; exp_op = o; end
      8'hC5: begin exp_bmode = 1'b1; exp_done = 1'b1; exp_op = o; end
      8'h06: begin exp_pulse = 1'b1; exp_done = 1'b1; exp_op = o; end
      8'hDB: if (n >= 16) begin exp_dir = a[5:2]; exp_done = 1'b1; exp_op = o; end
      default: ;
    endcase
  endtask

  task automatic frame(string ph, int n, logic [23:0] pat);
    phase = ph;
    @(negedge clk) wen = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdat = pat[23 - i];
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    wen = 1'b0;
    // R3: third rising edge after the strobe falls
    repeat (3) @(posedge clk);
    #1 apply_model(n, pat);
    @(posedge clk);
    #1 begin exp_pulse = 1'b0; exp_done = 1'b0; end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (running) begin
      running = 1'b0;
      errors++;
      $display("FAIL R3 watchdog expired: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;                                  // R1 checked during and after reset
    repeat (5) @(negedge clk);
    frame("R5 left dup", 8, {8'h29, 16'h0});
    frame("R4 stereo", 8, {8'h28, 16'h0});
    frame("R6 dir 0x2C", 16, {8'hDB, 8'h2C, 8'h0});
    frame("R6 dir 0xE7", 16, {8'hDB, 8'hE7, 8'h0});
    frame("R7 no operand", 8, {8'hDB, 16'h0});
    frame("R7 half operand", 12, {8'hDB, 8'hFF, 8'h0});
    frame("R10 short window", 5, {8'h29, 16'h0});
    frame("R10 unknown op", 8, {8'h55, 16'h0});
    frame("R10 unknown op 2", 16, {8'hDA, 8'hFF, 8'h0});
    frame("R8 brake mode", 8, {8'hC5, 16'h0});
    frame("R9 brake pulse", 8, {8'h06, 16'h0});
    frame("R8 stays after stereo", 8, {8'h28, 16'h0});
    // R2: shift clocks with strobe low are ignored
    phase = "R2 idle clocks";
    for (int i = 0; i < 10; i++) begin
      sdat = i[0];
      repeat (3) @(negedge clk); sclk = 1'b1;
      repeat (3) @(negedge clk); sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    frame("R2 after idle", 8, {8'h29, 16'h0});
    frame("R2 extra byte", 24, {8'hDB, 8'h3C, 8'hC3});
    frame("R2 extra after op", 24, {8'h28, 8'hDB, 8'h00});
    frame("R9 second pulse", 8, {8'h06, 16'h0});
    running = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule